// File: doc/BRIEF.md
# USB endpoint buffer CPU access port

This block lets a processor move packet data between its registers and a set of per-endpoint packet buffers of a USB device, one 32-bit word at a time. A small control register selects a logical endpoint and enables reading, writing or both. Reading the receive data port takes the next word of the selected endpoint's received (OUT) packet. A receive length view shows how many bytes are still unread, whether the packet arrived intact, and whether a packet is waiting at all. For the transmit (IN) direction, software first programs a byte length and then writes words until that many bytes have been supplied. The buffer is then handed to the bus side.

The bus side is a plain byte interface. It fills a receive buffer one byte per cycle and flags the last byte and any error. It drains a transmit buffer one byte per cycle. Draining of the last unread receive byte sets a sticky end-of-packet status, which software clears with a write-one-to-clear strobe.

Top module: `usb_ep_cpu_port`

## Requirements
- R1: After reset, `rx_len_o`, `rx_data_o` and `rx_eop_o` are 0, `bus_tx_rdy_o` is all 0 and `bus_rx_free_o` is all 1.
- R2: Receive words are little endian. Packet byte k sits in bits 8*(k mod 4)+7 down to 8*(k mod 4) of word k/4. Byte lanes beyond the packet end in the last word read as 0.
- R3: `rx_len_o` carries the remaining byte count in bits 9:0, the data-valid flag in bit 10 and the packet-ready flag in bit 11. Bits 31:12 are 0. The whole word reads 0 while the read enable is clear.
- R4: A read strobe accepted by a ready endpoint lowers the remaining count by min(4, remaining). The new count is visible in the next cycle.
- R5: When the count reaches 0, packet-ready and data-valid clear, `rx_eop_o` is set and the endpoint's `bus_rx_free_o` bit returns to 1. A free bit falls only when a last byte is written.
- R6: While the read enable is clear or no packet is ready, `rx_data_o` is 0 and a read strobe changes no count.
- R7: Data-valid is 1 for a packet whose last byte came without `bus_rx_err_i`, and 0 for one marked in error. The errored packet's bytes are still delivered.
- R8: `rx_eop_o` stays set until `eop_clr_i` is strobed. A new end-of-packet in the same cycle wins over the clear.
- R9: Transmit words are little endian: bits 7:0 of the first written word are the first byte drained on the bus side.
- R10: Transmit words are accepted only after a length write and only while the write enable is set. The endpoint becomes ready once the accepted bytes reach the length. Writes before the length, extra writes, and length or data writes with the write enable clear all have no effect.
- R11: All CPU-side reads and writes act only on the endpoint held in the control register, and other endpoints keep their state.
- R12: The bus side drains the programmed number of bytes in order, with `bus_tx_len_o` showing the length. The ready bit drops after the last byte. A length of 0 sets ready at once and one drain strobe releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_rd_en_i | input | 1 | Read enable value to store |
| ctrl_wr_en_i | input | 1 | Write enable value to store |
| ctrl_ep_i | input | EP_W | Logical endpoint to store |
| rx_rd_i | input | 1 | Receive data read strobe |
| rx_data_o | output | 32 | Receive data word |
| rx_len_o | output | 32 | Receive length and status view |
| tx_len_we_i | input | 1 | Transmit length write strobe |
| tx_len_i | input | 10 | Transmit packet length in bytes |
| tx_wr_i | input | 1 | Transmit data write strobe |
| tx_data_i | input | 32 | Transmit data word |
| eop_clr_i | input | 1 | Clear strobe for end-of-packet status |
| rx_eop_o | output | 1 | Sticky receive end-of-packet status |
| bus_rx_valid_i | input | 1 | Bus side receive byte strobe |
| bus_rx_ep_i | input | EP_W | Endpoint being filled |
| bus_rx_byte_i | input | 8 | Received byte |
| bus_rx_last_i | input | 1 | Byte is the last of the packet |
| bus_rx_err_i | input | 1 | Packet arrived with an error (with last) |
| bus_rx_free_o | output | NUM_EP | Receive buffer may be filled |
| bus_tx_rd_i | input | 1 | Bus side transmit byte take strobe |
| bus_tx_ep_i | input | EP_W | Endpoint being drained |
| bus_tx_byte_o | output | 8 | Next transmit byte of that endpoint |
| bus_tx_len_o | output | 10 | Programmed length of that endpoint |
| bus_tx_rdy_o | output | NUM_EP | Transmit buffer holds a complete packet |

## Verification
The properties assume a well-behaved bus side. It writes bytes only into endpoints whose free bit is set, never sends more bytes than a buffer holds, and never drains an endpoint that is not ready. On the CPU side, transmit lengths are assumed to fit the buffer. The stimulus picks fill endpoints from the free mask, bounds random packet sizes by the buffer capacity, and drains only ready endpoints for exactly their length. Control writes never coincide with a data read, which the countdown property requires.

// File: rtl/usb_epb_pkg.sv
package usb_epb_pkg;
  localparam int unsigned LEN_W = 10;
  typedef logic [LEN_W-1:0] len_t;

  typedef struct packed {
    logic [19:0] rsvd;
    logic        rdy;
    logic        dv;
    len_t        rem;
  } rx_len_t;

  // bytes carried by one word access
  function automatic len_t word_take(len_t left);
    return (left >= len_t'(4)) ? len_t'(4) : left;
  endfunction
endpackage

// File: rtl/usb_epb_out_buf.sv
module usb_epb_out_buf
  import usb_epb_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fill_i,
  input  logic [7:0]  fill_byte_i,
  input  logic        fill_last_i,
  input  logic        fill_err_i,
  input  logic        pop_i,
  output logic        rdy_o,
  output logic        dv_o,
  output len_t        rem_o,
  output logic [31:0] word_o,
  output logic        eop_o
);
  localparam int unsigned AW = $clog2(BUF_WORDS);

  logic [31:0]   mem [BUF_WORDS];
  len_t          fill_cnt_q, rem_q;
  logic [AW-1:0] rd_ptr_q;
  logic          rdy_q, dv_q;
  logic          fill_ok, pop_ok;
  logic [AW-1:0] widx;
  logic [1:0]    lane;

  assign fill_ok = fill_i && !rdy_q;
  assign pop_ok  = pop_i && rdy_q;
  assign widx    = fill_cnt_q[AW+1:2];
  assign lane    = fill_cnt_q[1:0];

  // first byte of a word clears the upper lanes
  always_ff @(posedge clk_i) begin
    if (fill_ok) begin
      if (lane == 2'd0) mem[widx] <= {24'd0, fill_byte_i};
      else              mem[widx][{lane, 3'b000} +: 8] <= fill_byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_cnt_q <= '0;
      rem_q      <= '0;
      rd_ptr_q   <= '0;
      rdy_q      <= 1'b0;
      dv_q       <= 1'b0;
    end else if (fill_ok) begin
      if (fill_last_i) begin
        rdy_q      <= 1'b1;
        dv_q       <= ~fill_err_i;
        rem_q      <= fill_cnt_q + len_t'(1);
        fill_cnt_q <= '0;
        rd_ptr_q   <= '0;
      end else begin
        fill_cnt_q <= fill_cnt_q + len_t'(1);
      end
    end else if (pop_ok) begin
      rem_q    <= rem_q - word_take(rem_q);
      rd_ptr_q <= rd_ptr_q + AW'(1);
      if (rem_q <= len_t'(4)) begin
        rdy_q <= 1'b0;
        dv_q  <= 1'b0;
      end
    end
  end

  assign rdy_o  = rdy_q;
  assign dv_o   = dv_q;
  assign rem_o  = rem_q;
  assign word_o = mem[rd_ptr_q];
  assign eop_o  = pop_ok && (rem_q <= len_t'(4));
endmodule

// File: rtl/usb_epb_in_buf.sv
module usb_epb_in_buf
  import usb_epb_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        len_we_i,
  input  len_t        len_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        drain_i,
  output logic        rdy_o,
  output len_t        len_o,
  output logic [7:0]  byte_o
);
  localparam int unsigned AW = $clog2(BUF_WORDS);

  logic [31:0] mem [BUF_WORDS];
  len_t        len_q, cnt_q, dptr_q, left, take;
  logic        armed_q, rdy_q, wr_ok, last_byte;

  assign left      = len_q - cnt_q;
  assign take      = word_take(left);
  assign wr_ok     = wr_i && armed_q && !rdy_q;
  assign last_byte = (len_q == '0) || (dptr_q + len_t'(1) >= len_q);

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[cnt_q[AW+1:2]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= '0;
      cnt_q   <= '0;
      dptr_q  <= '0;
      armed_q <= 1'b0;
      rdy_q   <= 1'b0;
    end else if (len_we_i && !rdy_q) begin
      len_q   <= len_i;
      cnt_q   <= '0;
      dptr_q  <= '0;
      armed_q <= (len_i != '0);
      rdy_q   <= (len_i == '0);
    end else if (wr_ok) begin
      cnt_q <= cnt_q + take;
      if (take == left) begin
        rdy_q   <= 1'b1;
        armed_q <= 1'b0;
      end
    end else if (drain_i && rdy_q) begin
      if (last_byte) begin
        rdy_q  <= 1'b0;
        dptr_q <= '0;
      end else begin
        dptr_q <= dptr_q + len_t'(1);
      end
    end
  end

  assign rdy_o  = rdy_q;
  assign len_o  = len_q;
  assign byte_o = mem[dptr_q[AW+1:2]][{dptr_q[1:0], 3'b000} +: 8];
endmodule

// File: rtl/usb_ep_cpu_port.sv
module usb_ep_cpu_port
  import usb_epb_pkg::*;
#(
  parameter int unsigned NUM_EP    = 4,
  parameter int unsigned BUF_WORDS = 16,
  localparam int unsigned EP_W     = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              ctrl_rd_en_i,
  input  logic              ctrl_wr_en_i,
  input  logic [EP_W-1:0]   ctrl_ep_i,
  input  logic              rx_rd_i,
  output logic [31:0]       rx_data_o,
  output logic [31:0]       rx_len_o,
  input  logic              tx_len_we_i,
  input  logic [LEN_W-1:0]  tx_len_i,
  input  logic              tx_wr_i,
  input  logic [31:0]       tx_data_i,
  input  logic              eop_clr_i,
  output logic              rx_eop_o,
  input  logic              bus_rx_valid_i,
  input  logic [EP_W-1:0]   bus_rx_ep_i,
  input  logic [7:0]        bus_rx_byte_i,
  input  logic              bus_rx_last_i,
  input  logic              bus_rx_err_i,
  output logic [NUM_EP-1:0] bus_rx_free_o,
  input  logic              bus_tx_rd_i,
  input  logic [EP_W-1:0]   bus_tx_ep_i,
  output logic [7:0]        bus_tx_byte_o,
  output logic [LEN_W-1:0]  bus_tx_len_o,
  output logic [NUM_EP-1:0] bus_tx_rdy_o
);
  logic            ctrl_rd_en_q, ctrl_wr_en_q;
  logic [EP_W-1:0] ctrl_ep_q;
  logic            eop_q;

  logic [NUM_EP-1:0] rx_rdy, rx_dv, rx_eop_pulse, tx_rdy;
  len_t              rx_rem  [NUM_EP];
  logic [31:0]       rx_word [NUM_EP];
  len_t              tx_len  [NUM_EP];
  logic [7:0]        tx_byte [NUM_EP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_rd_en_q <= 1'b0;
      ctrl_wr_en_q <= 1'b0;
      ctrl_ep_q    <= '0;
    end else if (ctrl_we_i) begin
      ctrl_rd_en_q <= ctrl_rd_en_i;
      ctrl_wr_en_q <= ctrl_wr_en_i;
      ctrl_ep_q    <= ctrl_ep_i;
    end
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic sel;
    assign sel = (ctrl_ep_q == EP_W'(e));

    usb_epb_out_buf #(.BUF_WORDS(BUF_WORDS)) i_out (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_i      (bus_rx_valid_i && (bus_rx_ep_i == EP_W'(e))),
      .fill_byte_i (bus_rx_byte_i),
      .fill_last_i (bus_rx_last_i),
      .fill_err_i  (bus_rx_err_i),
      .pop_i       (rx_rd_i && ctrl_rd_en_q && sel),
      .rdy_o       (rx_rdy[e]),
      .dv_o        (rx_dv[e]),
      .rem_o       (rx_rem[e]),
      .word_o      (rx_word[e]),
      .eop_o       (rx_eop_pulse[e])
    );

    usb_epb_in_buf #(.BUF_WORDS(BUF_WORDS)) i_in (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .len_we_i (tx_len_we_i && ctrl_wr_en_q && sel),
      .len_i    (tx_len_i),
      .wr_i     (tx_wr_i && ctrl_wr_en_q && sel),
      .wdata_i  (tx_data_i),
      .drain_i  (bus_tx_rd_i && (bus_tx_ep_i == EP_W'(e))),
      .rdy_o    (tx_rdy[e]),
      .len_o    (tx_len[e]),
      .byte_o   (tx_byte[e])
    );
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eop_q <= 1'b0;
    else         eop_q <= (|rx_eop_pulse) | (eop_q & ~eop_clr_i);
  end

  rx_len_t len_view;
  always_comb begin
    len_view = '0;
    if (ctrl_rd_en_q) begin
      len_view.rdy = rx_rdy[ctrl_ep_q];
      len_view.dv  = rx_dv[ctrl_ep_q];
      len_view.rem = rx_rem[ctrl_ep_q];
    end
  end

  assign rx_len_o      = len_view;
  assign rx_data_o     = (ctrl_rd_en_q && rx_rdy[ctrl_ep_q]) ? rx_word[ctrl_ep_q] : '0;
  assign rx_eop_o      = eop_q;
  assign bus_rx_free_o = ~rx_rdy;
  assign bus_tx_rdy_o  = tx_rdy;
  assign bus_tx_byte_o = tx_byte[bus_tx_ep_i];
  assign bus_tx_len_o  = tx_len[bus_tx_ep_i];
endmodule

// File: rtl/usb_epb_port_chk.sv
module usb_epb_port_chk #(
  parameter int unsigned NUM_EP = 4,
  localparam int unsigned EP_W  = $clog2(NUM_EP)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic              rx_rd_i,
  input logic [31:0]       rx_data_o,
  input logic [11:0]       rx_len_o,
  input logic              eop_clr_i,
  input logic              rx_eop_o,
  input logic              bus_rx_valid_i,
  input logic [EP_W-1:0]   bus_rx_ep_i,
  input logic              bus_rx_last_i,
  input logic [NUM_EP-1:0] bus_rx_free_o,
  input logic              bus_tx_rd_i,
  input logic [NUM_EP-1:0] bus_tx_rdy_o
);
  a_r4_rem_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && rx_len_o[11] && !ctrl_we_i) |=>
      rx_len_o[9:0] == $past(rx_len_o[9:0]) -
        (($past(rx_len_o[9:0]) >= 10'd4) ? 10'd4 : $past(rx_len_o[9:0])));

  a_r5_eop_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && rx_len_o[11] && (rx_len_o[9:0] <= 10'd4)) |=> rx_eop_o);

  a_r5_free_falls_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rx_valid_i && bus_rx_last_i) |=> (($past(bus_rx_free_o) & ~bus_rx_free_o) == '0));

  a_r5_fill_only_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rx_valid_i |-> bus_rx_free_o[bus_rx_ep_i]);

  a_r6_idle_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_len_o[11] |-> (rx_data_o == '0));

  a_r3_idle_len_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_len_o[11] |-> (rx_len_o[10:0] == '0));

  a_r8_eop_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_eop_o && !eop_clr_i) |=> rx_eop_o);

  a_r12_tx_rdy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_tx_rd_i |=> (($past(bus_tx_rdy_o) & ~bus_tx_rdy_o) == '0));
endmodule

bind usb_ep_cpu_port usb_epb_port_chk #(.NUM_EP(NUM_EP)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ctrl_we_i      (ctrl_we_i),
  .rx_rd_i        (rx_rd_i),
  .rx_data_o      (rx_data_o),
  .rx_len_o       (rx_len_o[11:0]),
  .eop_clr_i      (eop_clr_i),
  .rx_eop_o       (rx_eop_o),
  .bus_rx_valid_i (bus_rx_valid_i),
  .bus_rx_ep_i    (bus_rx_ep_i),
  .bus_rx_last_i  (bus_rx_last_i),
  .bus_rx_free_o  (bus_rx_free_o),
  .bus_tx_rd_i    (bus_tx_rd_i),
  .bus_tx_rdy_o   (bus_tx_rdy_o)
);

// File: tb/test_usb_ep_cpu_port.sv
module test_usb_ep_cpu_port;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        ctrl_we = 0, ctrl_rd_en = 0, ctrl_wr_en = 0;
  logic [1:0]  ctrl_ep = 0;
  logic        rx_rd = 0;
  logic [31:0] rx_data, rx_len;
  logic        tx_len_we = 0;
  logic [9:0]  tx_len = 0;
  logic        tx_wr = 0;
  logic [31:0] tx_data = 0;
  logic        eop_clr = 0, rx_eop;
  logic        brx_valid = 0, brx_last = 0, brx_err = 0;
  logic [1:0]  brx_ep = 0;
  logic [7:0]  brx_byte = 0;
  logic [3:0]  brx_free, btx_rdy;
  logic        btx_rd = 0;
  logic [1:0]  btx_ep = 0;
  logic [7:0]  btx_byte;
  logic [9:0]  btx_len;

  usb_ep_cpu_port i_usb_ep_cpu_port (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_rd_en_i(ctrl_rd_en), .ctrl_wr_en_i(ctrl_wr_en), .ctrl_ep_i(ctrl_ep),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_len_o(rx_len),
    .tx_len_we_i(tx_len_we), .tx_len_i(tx_len), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .eop_clr_i(eop_clr), .rx_eop_o(rx_eop),
    .bus_rx_valid_i(brx_valid), .bus_rx_ep_i(brx_ep), .bus_rx_byte_i(brx_byte),
    .bus_rx_last_i(brx_last), .bus_rx_err_i(brx_err), .bus_rx_free_o(brx_free),
    .bus_tx_rd_i(btx_rd), .bus_tx_ep_i(btx_ep), .bus_tx_byte_o(btx_byte),
    .bus_tx_len_o(btx_len), .bus_tx_rdy_o(btx_rdy)
  );

  int checks = 0, failures = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_rx   [NE][64];
  logic [7:0] m_fill [NE][64];
  logic [7:0] m_tx   [NE][64];
  int m_rx_h[NE], m_rx_n[NE], m_fill_n[NE];
  int m_tx_len[NE], m_tx_cnt[NE], m_tx_h[NE];
  bit m_rx_rdy[NE], m_rx_dv[NE], m_tx_rdy[NE], m_tx_arm[NE];
  bit m_rd_en = 0, m_wr_en = 0, m_eop = 0;
  int m_ep = 0;

  initial begin
    for (int e = 0; e < NE; e++) begin
      m_rx_h[e] = 0; m_rx_n[e] = 0; m_fill_n[e] = 0;
      m_tx_len[e] = 0; m_tx_cnt[e] = 0; m_tx_h[e] = 0;
      m_rx_rdy[e] = 0; m_rx_dv[e] = 0; m_tx_rdy[e] = 0; m_tx_arm[e] = 0;
    end
  end

  bit rr[NE], tr[NE];
  bit eop_set;
  int e, take;
  logic [31:0] x_len, x_data;
  logic [3:0]  x_free, x_trdy;

  always @(posedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NE; k++) begin rr[k] = m_rx_rdy[k]; tr[k] = m_tx_rdy[k]; end
      eop_set = 0;
      if (brx_valid && !rr[brx_ep]) begin
        e = brx_ep;
        m_fill[e][m_fill_n[e]] = brx_byte;
        m_fill_n[e]++;
        if (brx_last) begin
          for (int k = 0; k < m_fill_n[e]; k++) m_rx[e][k] = m_fill[e][k];
          m_rx_h[e] = 0; m_rx_n[e] = m_fill_n[e]; m_fill_n[e] = 0;
          m_rx_rdy[e] = 1; m_rx_dv[e] = !brx_err;
        end
      end
      if (rx_rd && m_rd_en && rr[m_ep]) begin
        take = (m_rx_n[m_ep] >= 4) ? 4 : m_rx_n[m_ep];
        m_rx_h[m_ep] += take; m_rx_n[m_ep] -= take;
        if (m_rx_n[m_ep] == 0) begin m_rx_rdy[m_ep] = 0; m_rx_dv[m_ep] = 0; eop_set = 1; end
      end
      if (eop_set) m_eop = 1; else if (eop_clr) m_eop = 0;
      if (tx_len_we && m_wr_en && !tr[m_ep]) begin
        m_tx_len[m_ep] = tx_len; m_tx_cnt[m_ep] = 0; m_tx_h[m_ep] = 0;
        m_tx_arm[m_ep] = (tx_len != 0); m_tx_rdy[m_ep] = (tx_len == 0);
      end else if (tx_wr && m_wr_en && m_tx_arm[m_ep] && !tr[m_ep]) begin
        take = m_tx_len[m_ep] - m_tx_cnt[m_ep];
        if (take > 4) take = 4;
        for (int k = 0; k < take; k++) m_tx[m_ep][m_tx_cnt[m_ep]+k] = tx_data[8*k +: 8];
        m_tx_cnt[m_ep] += take;
        if (m_tx_cnt[m_ep] == m_tx_len[m_ep]) begin m_tx_rdy[m_ep] = 1; m_tx_arm[m_ep] = 0; end
      end
      if (btx_rd && tr[btx_ep]) begin
        e = btx_ep;
        if (m_tx_len[e] == 0) m_tx_rdy[e] = 0;
        else begin
          m_tx_h[e]++;
          if (m_tx_h[e] == m_tx_len[e]) begin m_tx_rdy[e] = 0; m_tx_h[e] = 0; end
        end
      end
      if (ctrl_we) begin m_rd_en = ctrl_rd_en; m_wr_en = ctrl_wr_en; m_ep = ctrl_ep; end

      #2;
      x_len = 0; x_data = 0;
      if (m_rd_en && m_rx_rdy[m_ep]) begin
        x_len = {20'd0, 1'b1, m_rx_dv[m_ep], 10'(m_rx_n[m_ep])};
        for (int k = 0; k < 4; k++)
          if (k < m_rx_n[m_ep]) x_data[8*k +: 8] = m_rx[m_ep][m_rx_h[m_ep]+k];
      end
      for (int k = 0; k < NE; k++) begin x_free[k] = !m_rx_rdy[k]; x_trdy[k] = m_tx_rdy[k]; end
      chk("R3 rx_len per-cycle", rx_len, x_len);
      chk("R2 rx_data per-cycle", rx_data, x_data);
      chk("R8 eop per-cycle", {31'd0, rx_eop}, {31'd0, m_eop});
      chk("R5 rx_free per-cycle", {28'd0, brx_free}, {28'd0, x_free});
      chk("R10 tx_rdy per-cycle", {28'd0, btx_rdy}, {28'd0, x_trdy});
      if (m_tx_rdy[btx_ep] && m_tx_len[btx_ep] != 0) begin
        chk("R9 tx_byte per-cycle", {24'd0, btx_byte}, {24'd0, m_tx[btx_ep][m_tx_h[btx_ep]]});
        chk("R12 tx_len per-cycle", {22'd0, btx_len}, 32'(m_tx_len[btx_ep]));
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic set_ctrl(input bit rd, input bit wr, input int ep);
    @(negedge clk); ctrl_we = 1; ctrl_rd_en = rd; ctrl_wr_en = wr; ctrl_ep = 2'(ep);
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic fill(input int ep, input int n, input logic [7:0] base, input bit err);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      brx_valid = 1; brx_ep = 2'(ep); brx_byte = base + 8'(k);
      brx_last = (k == n - 1); brx_err = err;
    end
    @(negedge clk); brx_valid = 0; brx_last = 0; brx_err = 0;
  endtask

  task automatic rd();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic wr_len(input int n);
    @(negedge clk); tx_len_we = 1; tx_len = 10'(n);
    @(negedge clk); tx_len_we = 0;
  endtask

  task automatic wr_data(input logic [31:0] d);
    @(negedge clk); tx_wr = 1; tx_data = d;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic drain(input int ep);
    @(negedge clk); btx_rd = 1; btx_ep = 2'(ep);
    @(negedge clk); btx_rd = 0;
  endtask

  task automatic clr_eop();
    @(negedge clk); eop_clr = 1;
    @(negedge clk); eop_clr = 0;
  endtask

  bit finished = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_b [6];
    exp_b = '{8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'hFF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rx_len reset", rx_len, 32'h0);
    chk("R1 rx_data reset", rx_data, 32'h0);
    chk("R1 eop reset", {31'd0, rx_eop}, 32'h0);
    chk("R1 tx_rdy reset", {28'd0, btx_rdy}, 32'h0);
    chk("R1 rx_free reset", {28'd0, brx_free}, 32'hF);

    // receive, partial last word
    set_ctrl(1, 0, 1);
    fill(1, 7, 8'h10, 0);
    chk("R7 clean packet dv", rx_len, 32'h0000_0C07);
    chk("R2 first word", rx_data, 32'h1312_1110);
    rd();
    chk("R4 remaining after one read", {22'd0, rx_len[9:0]}, 32'd3);
    chk("R2 last word upper lanes zero", rx_data, 32'h0016_1514);
    rd();
    chk("R5 eop after final read", {31'd0, rx_eop}, 32'h1);
    chk("R5 length cleared", rx_len, 32'h0);
    chk("R5 buffer freed", {31'd0, brx_free[1]}, 32'h1);

    // reads with nothing ready / read enable clear
    rd();
    chk("R6 read with no packet", rx_data, 32'h0);
    fill(1, 5, 8'h40, 1);
    set_ctrl(0, 0, 1);
    chk("R6 data gated by rd_en", rx_data, 32'h0);
    chk("R3 length gated by rd_en", rx_len, 32'h0);
    rd();
    set_ctrl(1, 0, 1);
    chk("R6 count unchanged", rx_len, 32'h0000_0805);
    chk("R7 errored packet delivered", rx_data, 32'h4342_4140);

    // endpoint isolation
    fill(2, 2, 8'h70, 0);
    set_ctrl(1, 0, 2);
    chk("R11 ep2 length", rx_len, 32'h0000_0C02);
    chk("R11 ep2 data", rx_data, 32'h0000_7170);
    rd();
    set_ctrl(1, 0, 1);
    chk("R11 ep1 untouched", rx_len, 32'h0000_0805);

    // sticky eop
    chk("R8 eop still set", {31'd0, rx_eop}, 32'h1);
    clr_eop();
    chk("R8 eop cleared", {31'd0, rx_eop}, 32'h0);
    rd(); rd();
    chk("R8 eop set again", {31'd0, rx_eop}, 32'h1);
    chk("R5 all free", {28'd0, brx_free}, 32'hF);

    // transmit
    set_ctrl(0, 1, 3);
    wr_data(32'h1111_1111);
    wr_len(6);
    wr_data(32'hDDCC_BBAA);
    chk("R10 not ready mid packet", {28'd0, btx_rdy}, 32'h0);
    wr_data(32'h0000_FFEE);
    chk("R10 ready at length", {28'd0, btx_rdy}, 32'h8);
    wr_data(32'h9999_9999);
    btx_ep = 2'd3;
    #1;
    chk("R12 drain length", {22'd0, btx_len}, 32'd6);
    for (int k = 0; k < 6; k++) begin
      chk("R9 byte order", {24'd0, btx_byte}, {24'd0, exp_b[k]});
      drain(3);
    end
    chk("R12 released after last byte", {28'd0, btx_rdy}, 32'h0);

    // zero length
    set_ctrl(0, 1, 0);
    wr_len(0);
    chk("R12 zero length ready", {28'd0, btx_rdy}, 32'h1);
    drain(0);
    chk("R12 zero length released", {28'd0, btx_rdy}, 32'h0);

    // write enable clear
    set_ctrl(0, 0, 0);
    wr_len(0);
    chk("R10 length ignored without wr_en", {28'd0, btx_rdy}, 32'h0);

    // random traffic against the model
    for (int p = 0; p < 12; p++) begin
      int ep, n;
      ep = int'($urandom % NE);
      n  = 1 + int'($urandom % 64);
      fill(ep, n, 8'($urandom), bit'($urandom % 2));
      set_ctrl(1, 0, ep);
      for (int w = 0; w < (n + 3) / 4; w++) rd();
      chk("R4 packet fully read", {22'd0, rx_len[9:0]}, 32'd0);
      set_ctrl(0, 1, ep);
      wr_len(n);
      for (int w = 0; w < (n + 3) / 4; w++) wr_data($urandom);
      for (int b = 0; b < n; b++) drain(ep);
      chk("R12 random drain done", {28'd0, btx_rdy}, 32'h0);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule